// File: doc/BRIEF.md
# Programmable-Length Synchronous Serial Receiver

This block receives a serial bit stream that comes with its own clock. It samples a data line on each rising edge of a separate serial clock input. Each sample goes into a 32-bit shift register: the new bit enters at the top and the older bits move down one place. A length register can be written at any time. It sets how many shifts must happen before the whole shift register is copied into a holding register and a ready flag is raised. The host reads the holding register and clears the flag with a read strobe.

The shift register is never cleared. It always holds the last 32 bits received, so a word shorter than 32 bits appears in the upper bits of the holding register with older bits below it. The reader masks off the bits it does not want. Because writing the length only moves the capture point, software can rewrite the length while a word is arriving. This realigns word boundaries to a marker found in the stream, and no bits already received are lost. The serial clock and data lines are brought into the system clock domain through two flip-flops before the edge is detected.

Top module: `lenprog_srx`

## Requirements
- R1: After `rst` the ready flag is 0, the holding register reads 0, and the length is the default of 32 bits (length code 31).
- R2: A rising edge on `ser_clk` causes exactly one shift. Each high phase of `ser_clk` must last at least three `clk` cycles. The bit on `ser_dat` enters bit 31 and every older bit moves down one position. Falling edges cause no shift.
- R3: A length code N written through `len_wdata` (5 bits) gives a word of N+1 bits. The full 32-bit shift register is copied to the holding register on the (N+1)-th shift after the last capture, and ready is set on that copy.
- R4: Words shorter than 32 bits occupy the upper bits of the holding register. The bits below them are the previously received bits, in arrival order.
- R5: If the length is rewritten while a word is partly received, and the new code is not below the current count, the capture happens when the count reaches the new length. The bits already received stay in place.
- R6: A length write on its own changes neither the holding register nor the ready flag.
- R7: Ready stays set until `rd` is pulsed. A pulse of `rd` with no capture in the same cycle clears it.
- R8: When a capture and `rd` fall in the same cycle, ready stays set and the holding register takes the new word.
- R9: While `enable` is low, no shift occurs, the bit count is held at zero, and the holding register and shift register keep their contents. After release, the count starts again from zero.
- R10: `rst` does not clear the shift register. Bits received before a reset appear below the new bits in the first word captured after it. The bit count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable. When low, shifting stops and the count is held at zero |
| ser_clk | input | 1 | Serial shift clock, asynchronous to `clk` |
| ser_dat | input | 1 | Serial data, sampled on the rising edge of `ser_clk` |
| len_wr | input | 1 | Write strobe for the length register |
| len_wdata | input | 5 | Length code. The word length is the code plus one |
| rd | input | 1 | Read strobe. Clears ready |
| rd_data | output | 32 | Holding register |
| ready | output | 1 | Set when a new word has been captured |

## Verification
The hardest situation to reach from the ports is a capture and a host read landing on the same system clock edge. The capture edge lies three `clk` cycles after the serial clock rises. For this check the bench turns off its automatic reader and raises `rd` exactly on that edge. The other hard cases are the retained history: bits from before a reset or a disabled stretch, which must reappear in the lower part of a later short word. The bench reaches them by shifting a partial word, interrupting it, and then completing a short word. A reference model compares every bit position of that word.

// File: rtl/lenprog_srx_pkg.sv
package lenprog_srx_pkg;

    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // One detected serial-clock event, as seen in the system clock domain
    typedef struct packed {
        logic fire;    // a rising edge was seen and shifting is allowed
        logic bit_v;   // synchronized data value that goes with it
    } shift_evt_t;

    // What the shift core did in this cycle
    typedef enum logic [1:0] {
        EV_IDLE    = 2'd0,
        EV_SHIFT   = 2'd1,
        EV_CAPTURE = 2'd2
    } core_ev_t;

    // Default length code: all ones, which is the full width
    function automatic int unsigned full_len_code(input int unsigned word_w);
        return word_w - 1;
    endfunction

endpackage

// File: rtl/lenprog_srx_sync.sv
module lenprog_srx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = lenprog_srx_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/lenprog_srx_edge.sv
module lenprog_srx_edge
    import lenprog_srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       line_clk,
    input  logic       line_dat,
    output shift_evt_t evt
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= line_clk;
    end

    always_comb begin
        evt.fire  = line_clk & ~prev_q & enable & ~rst;
        evt.bit_v = line_dat;
    end
endmodule

// File: rtl/lenprog_srx_core.sv
module lenprog_srx_core
    import lenprog_srx_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int LEN_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  shift_evt_t        evt,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_wdata,
    output logic [WORD_W-1:0] sreg_q,
    output logic [LEN_W-1:0]  cnt_q,
    output logic              capture,
    output logic [WORD_W-1:0] cap_word,
    output core_ev_t          ev_kind
);
    localparam logic [LEN_W-1:0] LEN_RESET = LEN_W'(full_len_code(WORD_W));

    logic [LEN_W-1:0]  len_q;
    logic [WORD_W-1:0] sreg_next;
    logic              at_len;

    assign sreg_next = {evt.bit_v, sreg_q[WORD_W-1:1]};
    assign at_len    = (cnt_q == len_q);
    assign capture   = evt.fire & at_len;
    assign cap_word  = sreg_next;

    always_comb begin
        if (capture)       ev_kind = EV_CAPTURE;
        else if (evt.fire) ev_kind = EV_SHIFT;
        else               ev_kind = EV_IDLE;
    end

    // The shift register has no reset and no clear: only a shift event moves it
    always_ff @(posedge clk) begin
        if (evt.fire) sreg_q <= sreg_next;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt_q <= '0;
        end else begin
            case (ev_kind)
                EV_CAPTURE: cnt_q <= '0;
                EV_SHIFT:   cnt_q <= cnt_q + 1'b1;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         len_q <= LEN_RESET;
        else if (len_wr) len_q <= len_wdata;
    end
endmodule

// File: rtl/lenprog_srx_hold.sv
module lenprog_srx_hold #(
    parameter int WORD_W = lenprog_srx_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [WORD_W-1:0] cap_word,
    input  logic              rd,
    output logic [WORD_W-1:0] hold_q,
    output logic              ready_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            ready_q <= 1'b0;
        end else if (capture) begin
            hold_q  <= cap_word;
            ready_q <= 1'b1;
        end else if (rd) begin
            ready_q <= 1'b0;
        end
    end
endmodule

// File: rtl/lenprog_srx.sv
module lenprog_srx
    import lenprog_srx_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int STAGES  = DEF_SYNC_STAGES,
    localparam int LEN_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              rd,
    output logic [WORD_W-1:0] rd_data,
    output logic              ready
);
    logic [1:0]        line_sync;
    shift_evt_t        evt;
    logic [WORD_W-1:0] sreg_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              capture;
    logic [WORD_W-1:0] cap_word;
    core_ev_t          ev_kind;
    logic              shift_fire;

    lenprog_srx_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({ser_clk, ser_dat}),
        .sync_out (line_sync)
    );

    lenprog_srx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .line_clk (line_sync[1]),
        .line_dat (line_sync[0]),
        .evt      (evt)
    );

    lenprog_srx_core #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .evt       (evt),
        .len_wr    (len_wr),
        .len_wdata (len_wdata),
        .sreg_q    (sreg_q),
        .cnt_q     (cnt_q),
        .capture   (capture),
        .cap_word  (cap_word),
        .ev_kind   (ev_kind)
    );

    lenprog_srx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .cap_word (cap_word),
        .rd       (rd),
        .hold_q   (rd_data),
        .ready_q  (ready)
    );

    assign shift_fire = evt.fire;
endmodule

// File: rtl/lenprog_srx_chk.sv
module lenprog_srx_chk #(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              fire,
    input logic              capture,
    input logic [WORD_W-1:0] cap_word,
    input logic [LEN_W-1:0]  cnt,
    input logic              rd,
    input logic              ready,
    input logic [WORD_W-1:0] hold
);
    // R1: reset leaves the flag low and the holding register empty
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!ready && hold == '0));

    // R7: a read with no capture in the same cycle drops the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd && !capture) |=> !ready);

    // R8: a capture always leaves the flag set with the new word, read or not
    a_r8_capture_wins: assert property (@(posedge clk) disable iff (rst)
        capture |=> (ready && hold == $past(cap_word)));

    // R6: the holding register only moves on a capture
    a_r6_hold_only_on_capture: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(hold));

    // R9: while disabled, no shift event fires and the count is held at zero
    a_r9_no_fire_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !fire);
    a_r9_count_zero: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0));

    // R3: a capture is a shift event
    a_r3_capture_is_shift: assert property (@(posedge clk) disable iff (rst)
        capture |-> fire);
endmodule

bind lenprog_srx lenprog_srx_chk #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .fire     (shift_fire),
    .capture  (capture),
    .cap_word (cap_word),
    .cnt      (cnt_q),
    .rd       (rd),
    .ready    (ready),
    .hold     (rd_data)
);

// File: tb/lenprog_srx_bench.sv
module lenprog_srx_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        len_wr = 1'b0;
    logic [4:0]  len_wdata = 5'd0;
    logic        seq_rd = 1'b0;
    logic        mon_rd = 1'b0;
    logic        rd;
    logic [31:0] rd_data;
    logic        ready;

    int n_chk = 0;
    int n_fail = 0;
    bit auto_rd = 1'b1;
    bit done = 1'b0;

    // reference model
    logic [31:0] m_sr = '0;
    int          m_cnt = 0;
    int          m_len = 31;
    logic [31:0] last_exp = '0;
    string       cur_tag = "R1";
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign rd = seq_rd | mon_rd;

    lenprog_srx u_lenprog_srx (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .len_wr    (len_wr),
        .len_wdata (len_wdata),
        .rd        (rd),
        .rd_data   (rd_data),
        .ready     (ready)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops and compares each word the design captures
    always @(negedge clk) begin
        if (mon_rd) begin
            mon_rd = 1'b0;
        end else if (auto_rd && ready && !rst) begin
            if (exp_q.size() == 0) begin
                chk("unexpected capture", rd_data, 32'hxxxx_xxxx);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
            mon_rd = 1'b1;
        end
    end

    task automatic model_shift(input logic b);
        if (enable && !rst) begin
            m_sr = {b, m_sr[31:1]};
            if (m_cnt == m_len) begin
                if (auto_rd) begin
                    exp_q.push_back(m_sr);
                    tag_q.push_back(cur_tag);
                end else begin
                    last_exp = m_sr;
                end
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        model_shift(b);
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    // shift one bit with rd raised on the exact capture edge
    task automatic send_bit_rd(input logic b);
        ser_dat = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        model_shift(b);
        @(negedge clk);
        @(negedge clk);
        seq_rd = 1'b1;
        @(negedge clk);
        seq_rd = 1'b0;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_len(input logic [4:0] v);
        @(negedge clk);
        len_wdata = v;
        len_wr = 1'b1;
        @(negedge clk);
        len_wr = 1'b0;
        m_len = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        m_cnt = 0;
        m_len = 31;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain();
        repeat (20) @(negedge clk);
    endtask

    initial begin
        logic [31:0] snap;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state, then the default length gives a full 32-bit word
        chk("R1 ready after reset", {31'd0, ready}, 32'd0);
        chk("R1 holding after reset", rd_data, 32'd0);
        cur_tag = "R1 default 32-bit word";
        send_bits(32'hC3A5_1E69, 32);
        drain();

        // R2: another full word, distinct pattern
        cur_tag = "R2 shift order";
        send_bits(32'h0F0F_6A9C, 32);
        drain();

        // R6: a length write touches neither holding register nor flag
        snap = rd_data;
        write_len(5'd7);
        repeat (3) @(negedge clk);
        chk("R6 ready after length write", {31'd0, ready}, 32'd0);
        chk("R6 holding after length write", rd_data, snap);

        // R3/R4: 8-bit words land on top of older bits
        cur_tag = "R3 8-bit word";
        send_bits(32'h0000_00B4, 8);
        cur_tag = "R4 short word keeps history";
        send_bits(32'h0000_3C5A, 16);
        drain();

        // R5: rewrite length mid-word, 5 bits in
        write_len(5'd15);
        send_bits(32'h0000_0016, 5);
        snap = rd_data;
        write_len(5'd17);
        chk("R5 no capture at length rewrite", {31'd0, ready}, 32'd0);
        chk("R6 holding kept across rewrite", rd_data, snap);
        cur_tag = "R5 capture at new length";
        send_bits(32'h0000_1D2B, 13);
        drain();

        // R9: disabled stretch drops edges and restarts the count
        send_bits(32'h0000_0005, 3);
        enable = 1'b0;
        @(negedge clk);
        snap = rd_data;
        send_bits(32'h0000_003F, 6);
        chk("R9 no capture while disabled", {31'd0, ready}, 32'd0);
        chk("R9 holding kept while disabled", rd_data, snap);
        enable = 1'b1;
        m_cnt = 0;
        @(negedge clk);
        cur_tag = "R9 count restarts after enable";
        send_bits(32'h0002_A4C3, 18);
        drain();

        // R10: reset mid-word keeps the shift register
        write_len(5'd7);
        send_bits(32'h0000_000A, 4);
        do_reset();
        chk("R10 ready cleared by reset", {31'd0, ready}, 32'd0);
        chk("R10 holding cleared by reset", rd_data, 32'd0);
        write_len(5'd7);
        cur_tag = "R10 pre-reset bits retained";
        send_bits(32'h0000_0093, 8);
        drain();

        // R7/R8: manual reads
        auto_rd = 1'b0;
        write_len(5'd0);
        send_bit(1'b1);
        chk("R3 1-bit word", rd_data, last_exp);
        repeat (10) @(negedge clk);
        chk("R7 ready held until read", {31'd0, ready}, 32'd1);
        send_bit_rd(1'b0);
        chk("R8 ready kept on coincident read", {31'd0, ready}, 32'd1);
        chk("R8 holding takes new word", rd_data, last_exp);
        @(negedge clk);
        seq_rd = 1'b1;
        @(negedge clk);
        seq_rd = 1'b0;
        chk("R7 read clears ready", {31'd0, ready}, 32'd0);

        chk("all expected words seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule